// File: doc/BRIEF.md
# Accumulator Round-Shift-Clamp Readout

This block converts a bank of wide signed accumulator lanes into one packed 64-bit result. Each lane is shifted right by its own amount, rounded with one of six rounding modes, and saturated to the width of the packed lane. Two lane layouts are supported. The halfword layout has four 48-bit accumulator lanes that produce four 16-bit results. The byte layout has eight 24-bit accumulator lanes that produce eight 8-bit results. Both layouts share the same 192-bit accumulator bus.

The shift amounts come from one of three sources, picked per transaction:
- one element of a 64-bit operand word, applied to every lane;
- the matching lane of that operand word, so each lane has its own shift;
- a 5-bit immediate.

A transaction is presented with `in_valid`. The result appears on the registered output stage in the next cycle. When the request is undefined, an unpredictable flag is raised and the affected lanes read as zero. The requests that count as undefined are a signed mode in byte layout, a reserved mode code, and a negative halfword shift amount.

The output stage is a two-state machine:
- `OS_IDLE`: nothing to present.
- `OS_HOLD`: a result is shown.

Its transitions are:
- `OS_IDLE`→`OS_HOLD` and `OS_HOLD`→`OS_HOLD` on `in_valid`.
- `OS_HOLD`→`OS_IDLE` and `OS_IDLE`→`OS_IDLE` without `in_valid`.

Top module: `acc_rsc_top`

## Requirements
- R1: One clock edge after `in_valid` is high, `out_valid` is high and `out_data`/`out_unpred` hold that transaction's result. After an edge with `in_valid` low, `out_valid` is low and `out_data`/`out_unpred` keep their previous values.
- R2: Mode code bits [2:1] select the rounding kind: 0 is nearest-away, 1 is nearest-even, 2 is truncate. Bit 0 set means unsigned, bit 0 clear means signed. Nearest-away (codes 0 and 1) rounds up when the discarded fraction is at least one half. The one exception is a negative signed value, which rounds up only above one half, so exact halves move away from zero.
- R3: Nearest-even (codes 2 and 3) rounds up when the discarded fraction exceeds one half. On an exact half it rounds up only when the kept least significant bit is 1.
- R4: Signed truncate (code 4) rounds toward zero: a negative value with a nonzero discarded fraction ends one above its arithmetic-shift floor. Unsigned truncate (code 5) is a plain logical shift.
- R5: The signed halfword modes saturate to -32768..32767. The unsigned modes read the accumulator as a 48-bit (or 24-bit) unsigned number and saturate to 0..65535 (or 0..255).
- R6: `in_fmt`=0 selects the byte layout and `in_fmt`=1 the halfword layout. In byte layout a signed mode (codes 0, 2, 4) raises `out_unpred` and gives an all-zero result.
- R7: A shift at or above the accumulator width (48 or 24) acts as a shift of exactly that width. The exception is unsigned truncate, which gives 1 when the masked accumulator exceeds 2^47 (or 2^23) and 0 otherwise.
- R8: `in_sel` selects the shift source:
  - 0 takes operand element `in_elem`: halfword index `in_elem[1:0]`, byte index `in_elem[2:0]`.
  - 1 takes operand lane i for result lane i.
  - 2 and 3 take `in_imm` zero-extended.
  
  Lane i sits at bits i*16 (halfword) or i*8 (byte) of the operand and result, and at i*48 or i*24 of the accumulator bus.
- R9: A halfword shift amount with bit 15 set raises `out_unpred` and forces only that lane to zero. The other lanes are computed normally.
- R10: Mode codes 6 and 7 raise `out_unpred` and give an all-zero result in both layouts.
- R11: While `rst_n` is low, and until the first transaction, `out_valid`, `out_data` and `out_unpred` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Transaction present this cycle |
| in_fmt | input | 1 | 0 byte layout, 1 halfword layout |
| in_mode | input | 3 | Rounding mode code |
| in_sel | input | 2 | Shift source select |
| in_elem | input | 3 | Element index for element select |
| in_imm | input | 5 | Immediate shift amount |
| in_acc | input | 192 | Packed accumulator lanes |
| in_opnd | input | 64 | Operand word carrying shift amounts |
| out_valid | output | 1 | Registered result valid |
| out_data | output | 64 | Packed rounded and clamped result |
| out_unpred | output | 1 | Unpredictable-result flag |

## Verification
The properties assume that every transaction input is known and held steady across the sampling edge whenever `in_valid` is high. The idle property additionally assumes that `out_data` may be compared against its previous sample only after reset has released. The bench meets both assumptions by changing every input on the falling clock edge and leaving `in_valid` low through reset. Random shift amounts are drawn mostly small, so rounding and saturation are exercised, with a minority that are wide or have bit 15 set, so the wide-shift rule and the per-lane undefined path are reached too.

// File: rtl/acc_rsc_pkg.sv
package acc_rsc_pkg;

    // Lane layout selected by in_fmt
    typedef enum logic {
        FMT_BYTE = 1'b0,
        FMT_HALF = 1'b1
    } lane_fmt_e;

    // Shift amount source selected by in_sel
    typedef enum logic [1:0] {
        SRC_ELEM = 2'd0,
        SRC_LANE = 2'd1,
        SRC_IMM  = 2'd2,
        SRC_IMM2 = 2'd3
    } shift_src_e;

    // Rounding kind, bits [2:1] of the mode code
    typedef enum logic [1:0] {
        RK_AWAY  = 2'd0,
        RK_EVEN  = 2'd1,
        RK_TRUNC = 2'd2,
        RK_RSVD  = 2'd3
    } round_kind_e;

    // Output stage states
    typedef enum logic {
        OS_IDLE = 1'b0,
        OS_HOLD = 1'b1
    } ostate_e;

endpackage

// File: rtl/acc_rsc_shsel.sv
module acc_rsc_shsel
    import acc_rsc_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int HW     = 16,
    parameter int BW     = 8,
    parameter int IMM_W  = 5,
    localparam int HL     = DATA_W / HW,
    localparam int BL     = DATA_W / BW,
    localparam int ELEM_W = $clog2(BL),
    localparam int HIDX_W = $clog2(HL)
) (
    input  logic [1:0]        sel,
    input  logic [ELEM_W-1:0] elem,
    input  logic [IMM_W-1:0]  imm,
    input  logic [DATA_W-1:0] opnd,
    output logic [DATA_W-1:0] h_sh,
    output logic [DATA_W-1:0] b_sh
);

    logic [HIDX_W-1:0] h_idx;
    assign h_idx = elem[HIDX_W-1:0];

    for (genvar g = 0; g < HL; g++) begin : g_half
        always_comb begin
            unique case (shift_src_e'(sel))
                SRC_ELEM: h_sh[g*HW +: HW] = opnd[h_idx*HW +: HW];
                SRC_LANE: h_sh[g*HW +: HW] = opnd[g*HW +: HW];
                default:  h_sh[g*HW +: HW] = HW'(imm);
            endcase
        end
    end

    for (genvar g = 0; g < BL; g++) begin : g_byte
        always_comb begin
            unique case (shift_src_e'(sel))
                SRC_ELEM: b_sh[g*BW +: BW] = opnd[elem*BW +: BW];
                SRC_LANE: b_sh[g*BW +: BW] = opnd[g*BW +: BW];
                default:  b_sh[g*BW +: BW] = BW'(imm);
            endcase
        end
    end

endmodule

// File: rtl/acc_rnd_lane.sv
module acc_rnd_lane
    import acc_rsc_pkg::*;
#(
    parameter int ACC_W = 48,
    parameter int OUT_W = 16,
    parameter int SH_W  = 15,
    localparam int EXT_W = ACC_W + 1,
    localparam int SUM_W = ACC_W + 2,
    localparam int CAP_W = $clog2(ACC_W + 1)
) (
    input  logic [ACC_W-1:0] acc,
    input  logic [SH_W-1:0]  shamt,
    input  logic [2:0]       mode,
    output logic [OUT_W-1:0] res
);

    localparam logic signed [SUM_W-1:0] SMAX = SUM_W'((64'd1 << (OUT_W - 1)) - 64'd1);
    localparam logic signed [SUM_W-1:0] SMIN = ~SMAX;
    localparam logic signed [SUM_W-1:0] UMAX = SUM_W'((64'd1 << OUT_W) - 64'd1);

    logic                    signed_md;
    logic                    wide;
    logic                    big;
    logic [CAP_W-1:0]        cap;
    logic signed [EXT_W-1:0] ext;
    logic signed [EXT_W-1:0] fl;
    logic [EXT_W-1:0]        below;
    logic [EXT_W-1:0]        gmask;
    logic                    guard;
    logic                    sticky;
    logic                    neg;
    logic                    up;
    logic signed [SUM_W-1:0] sum;

    // Shift capping and discarded-bit analysis
    always_comb begin
        signed_md = ~mode[0];
        wide      = ({{(32-SH_W){1'b0}}, shamt} >= 32'(ACC_W));
        big       = (acc > {1'b1, {(ACC_W-1){1'b0}}});
        cap       = wide ? CAP_W'(ACC_W) : shamt[CAP_W-1:0];
        ext       = {signed_md & acc[ACC_W-1], acc};
        fl        = ext >>> cap;
        below     = (EXT_W'(1) << cap) - EXT_W'(1);
        gmask     = (cap == '0) ? '0 : (EXT_W'(1) << (cap - CAP_W'(1)));
        guard     = |(ext & gmask);
        sticky    = |(ext & below & ~gmask);
        neg       = ext[EXT_W-1];
    end

    // Round-up decision per rounding kind
    always_comb begin
        unique case (round_kind_e'(mode[2:1]))
            RK_AWAY:  up = guard & (~neg | sticky);
            RK_EVEN:  up = guard & (sticky | fl[0]);
            RK_TRUNC: up = neg & (guard | sticky);
            default:  up = 1'b0;
        endcase
    end

    // Increment, wide unsigned-truncate rule, saturation
    always_comb begin
        sum = $signed({fl[EXT_W-1], fl}) + $signed({{(SUM_W-1){1'b0}}, up});
        if (mode == 3'd5 && wide) begin
            sum = $signed({{(SUM_W-1){1'b0}}, big});
        end
        if (signed_md) begin
            if (sum > SMAX)      res = SMAX[OUT_W-1:0];
            else if (sum < SMIN) res = SMIN[OUT_W-1:0];
            else                 res = sum[OUT_W-1:0];
        end else begin
            if (sum > UMAX)      res = {OUT_W{1'b1}};
            else                 res = sum[OUT_W-1:0];
        end
    end

endmodule

// File: rtl/acc_rsc_ostage.sv
module acc_rsc_ostage
    import acc_rsc_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] d_data,
    input  logic              d_unpred,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_unpred
);

    ostate_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= OS_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        unique case (state_q)
            OS_IDLE: state_d = in_valid ? OS_HOLD : OS_IDLE;
            OS_HOLD: state_d = in_valid ? OS_HOLD : OS_IDLE;
            default: state_d = OS_IDLE;
        endcase
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_data   <= '0;
            out_unpred <= 1'b0;
        end else if (in_valid) begin
            out_data   <= d_data;
            out_unpred <= d_unpred;
        end
    end

    assign out_valid = (state_q == OS_HOLD);

endmodule

// File: rtl/acc_rsc_top.sv
module acc_rsc_top
    import acc_rsc_pkg::*;
#(
    parameter int DATA_W  = 64,
    parameter int HW      = 16,
    parameter int BW      = 8,
    parameter int H_ACC_W = 48,
    parameter int B_ACC_W = 24,
    parameter int IMM_W   = 5,
    localparam int HL      = DATA_W / HW,
    localparam int BL      = DATA_W / BW,
    localparam int ELEM_W  = $clog2(BL),
    localparam int ACC_BUS = HL * H_ACC_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               in_fmt,
    input  logic [2:0]         in_mode,
    input  logic [1:0]         in_sel,
    input  logic [ELEM_W-1:0]  in_elem,
    input  logic [IMM_W-1:0]   in_imm,
    input  logic [ACC_BUS-1:0] in_acc,
    input  logic [DATA_W-1:0]  in_opnd,
    output logic               out_valid,
    output logic [DATA_W-1:0]  out_data,
    output logic               out_unpred
);

    logic [DATA_W-1:0] h_sh, b_sh;
    logic [DATA_W-1:0] h_raw, b_raw, h_res, b_res;
    logic [HL-1:0]     h_bad;
    logic              mode_bad;
    logic              byte_bad;
    logic [DATA_W-1:0] c_data;
    logic              c_unpred;

    assign mode_bad = (round_kind_e'(in_mode[2:1]) == RK_RSVD);
    assign byte_bad = mode_bad | ~in_mode[0];

    acc_rsc_shsel #(.DATA_W(DATA_W), .HW(HW), .BW(BW), .IMM_W(IMM_W)) u_shsel (
        .sel  (in_sel),
        .elem (in_elem),
        .imm  (in_imm),
        .opnd (in_opnd),
        .h_sh (h_sh),
        .b_sh (b_sh)
    );

    for (genvar g = 0; g < HL; g++) begin : g_hlane
        acc_rnd_lane #(.ACC_W(H_ACC_W), .OUT_W(HW), .SH_W(HW - 1)) u_lane (
            .acc   (in_acc[g*H_ACC_W +: H_ACC_W]),
            .shamt (h_sh[g*HW +: HW-1]),
            .mode  (in_mode),
            .res   (h_raw[g*HW +: HW])
        );
        assign h_bad[g] = h_sh[g*HW + HW - 1];
        assign h_res[g*HW +: HW] = (h_bad[g] | mode_bad) ? '0 : h_raw[g*HW +: HW];
    end

    for (genvar g = 0; g < BL; g++) begin : g_blane
        acc_rnd_lane #(.ACC_W(B_ACC_W), .OUT_W(BW), .SH_W(BW)) u_lane (
            .acc   (in_acc[g*B_ACC_W +: B_ACC_W]),
            .shamt (b_sh[g*BW +: BW]),
            .mode  (in_mode),
            .res   (b_raw[g*BW +: BW])
        );
        assign b_res[g*BW +: BW] = byte_bad ? '0 : b_raw[g*BW +: BW];
    end

    always_comb begin
        unique case (lane_fmt_e'(in_fmt))
            FMT_HALF: begin
                c_data   = h_res;
                c_unpred = mode_bad | (|h_bad);
            end
            default: begin
                c_data   = b_res;
                c_unpred = byte_bad;
            end
        endcase
    end

    acc_rsc_ostage #(.DATA_W(DATA_W)) u_ostage (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .d_data     (c_data),
        .d_unpred   (c_unpred),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .out_unpred (out_unpred)
    );

endmodule

// File: rtl/acc_rsc_chk.sv
module acc_rsc_chk (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic         in_fmt,
    input logic [2:0]   in_mode,
    input logic [1:0]   in_sel,
    input logic [63:0]  in_opnd,
    input logic         out_valid,
    input logic [63:0]  out_data,
    input logic         out_unpred
);

    assert_valid_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_data) && $stable(out_unpred)));

    assert_byte_signed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_fmt && !in_mode[0]) |=> (out_unpred && out_data == 64'd0));

    assert_rsvd_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode[2] && in_mode[1]) |=> (out_unpred && out_data == 64'd0));

    assert_imm_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_fmt && in_sel[1] && !(in_mode[2] && in_mode[1])) |=> !out_unpred);

    assert_neg_shift_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_fmt && in_sel == 2'd1 && in_opnd[15]) |=> (out_unpred && out_data[15:0] == 16'd0));

endmodule

bind acc_rsc_top acc_rsc_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_fmt     (in_fmt),
    .in_mode    (in_mode),
    .in_sel     (in_sel),
    .in_opnd    (in_opnd),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_unpred (out_unpred)
);

// File: tb/acc_rsc_top_tb.sv
module acc_rsc_top_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_fmt = 1'b0;
    logic [2:0]   in_mode = '0;
    logic [1:0]   in_sel = '0;
    logic [2:0]   in_elem = '0;
    logic [4:0]   in_imm = '0;
    logic [191:0] in_acc = '0;
    logic [63:0]  in_opnd = '0;
    logic         out_valid;
    logic [63:0]  out_data;
    logic         out_unpred;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    acc_rsc_top u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_fmt     (in_fmt),
        .in_mode    (in_mode),
        .in_sel     (in_sel),
        .in_elem    (in_elem),
        .in_imm     (in_imm),
        .in_acc     (in_acc),
        .in_opnd    (in_opnd),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .out_unpred (out_unpred)
    );

    task automatic check(input string req, input string what, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    // Independent model of one lane: floor, fraction, compare against one half
    function automatic longint lane_val(input longint raw, input int w, input int ow,
                                        input bit sg, input int kind, input int s);
        longint a, fl, frac, half, r, mx, mn;
        int sc;
        bit up;
        a = raw;
        if (sg && raw[w-1]) a = raw - (longint'(1) <<< w);
        if (!sg && kind == 2 && s >= w) begin
            r = (a > (longint'(1) <<< (w - 1))) ? 1 : 0;
        end else begin
            sc   = (s > w) ? w : s;
            fl   = a >>> sc;
            frac = a - (fl <<< sc);
            up   = 1'b0;
            if (sc > 0) begin
                half = longint'(1) <<< (sc - 1);
                case (kind)
                    0:       up = (sg && a < 0) ? (frac > half) : (frac >= half);
                    1:       up = (frac > half) || (frac == half && fl[0]);
                    default: up = sg && a < 0 && frac != 0;
                endcase
            end
            r = fl + longint'(up);
        end
        if (sg) begin
            mx = (longint'(1) <<< (ow - 1)) - 1;
            mn = -(longint'(1) <<< (ow - 1));
            if (r > mx) r = mx;
            if (r < mn) r = mn;
        end else begin
            mx = (longint'(1) <<< ow) - 1;
            if (r > mx) r = mx;
        end
        return r & ((longint'(1) <<< ow) - 1);
    endfunction

    task automatic model(input logic fmt, input logic [2:0] mode, input logic [1:0] sel,
                         input logic [2:0] elem, input logic [4:0] imm, input logic [191:0] acc,
                         input logic [63:0] opnd, output logic [63:0] d, output logic u);
        bit bad_mode;
        logic [15:0] sh16;
        logic [7:0]  sh8;
        longint v;
        bad_mode = (mode > 3'd5);
        d = '0;
        u = 1'b0;
        if (fmt) begin
            for (int i = 0; i < 4; i++) begin
                if (sel == 2'd0)      sh16 = opnd[elem[1:0]*16 +: 16];
                else if (sel == 2'd1) sh16 = opnd[i*16 +: 16];
                else                  sh16 = {11'd0, imm};
                if (bad_mode || sh16[15]) begin
                    u = 1'b1;
                end else begin
                    v = lane_val(longint'(acc[i*48 +: 48]), 48, 16, !mode[0], int'(mode[2:1]), int'(sh16));
                    d[i*16 +: 16] = v[15:0];
                end
            end
            if (bad_mode) u = 1'b1;
        end else begin
            if (bad_mode || !mode[0]) begin
                u = 1'b1;
            end else begin
                for (int i = 0; i < 8; i++) begin
                    if (sel == 2'd0)      sh8 = opnd[elem*8 +: 8];
                    else if (sel == 2'd1) sh8 = opnd[i*8 +: 8];
                    else                  sh8 = {3'd0, imm};
                    v = lane_val(longint'(acc[i*24 +: 24]), 24, 8, 1'b0, int'(mode[2:1]), int'(sh8));
                    d[i*8 +: 8] = v[7:0];
                end
            end
        end
    endtask

    function automatic string tag_for(input logic fmt, input logic [2:0] mode);
        if (mode > 3'd5)           return "R10";
        if (!fmt && !mode[0])      return "R6";
        if (mode[2:1] == 2'd0)     return "R2";
        if (mode[2:1] == 2'd1)     return "R3";
        return "R4";
    endfunction

    // Drive on the falling edge, check on the next falling edge (one register stage)
    task automatic run(input logic fmt, input logic [2:0] mode, input logic [1:0] sel,
                       input logic [2:0] elem, input logic [4:0] imm, input logic [191:0] acc,
                       input logic [63:0] opnd, input string tag);
        logic [63:0] ed;
        logic eu;
        in_fmt = fmt; in_mode = mode; in_sel = sel; in_elem = elem;
        in_imm = imm; in_acc = acc; in_opnd = opnd; in_valid = 1'b1;
        model(fmt, mode, sel, elem, imm, acc, opnd, ed, eu);
        @(negedge clk);
        check("R1", "out_valid", {63'd0, out_valid}, 64'd1);
        check(tag, "data", out_data, ed);
        check(tag, "unpred", {63'd0, out_unpred}, {63'd0, eu});
    endtask

    task automatic idle_check();
        logic [63:0] pd;
        logic pu;
        pd = out_data;
        pu = out_unpred;
        in_valid = 1'b0;
        in_acc   = {$urandom(), $urandom(), $urandom(), $urandom(), $urandom(), $urandom()};
        in_mode  = 3'd7;
        @(negedge clk);
        check("R1", "idle out_valid", {63'd0, out_valid}, 64'd0);
        check("R1", "idle data held", out_data, pd);
        check("R1", "idle unpred held", {63'd0, out_unpred}, {63'd0, pu});
    endtask

    function automatic logic [191:0] p4(input longint a0, input longint a1, input longint a2, input longint a3);
        return {a3[47:0], a2[47:0], a1[47:0], a0[47:0]};
    endfunction

    function automatic logic [63:0] o4(input logic [15:0] s0, input logic [15:0] s1,
                                      input logic [15:0] s2, input logic [15:0] s3);
        return {s3, s2, s1, s0};
    endfunction

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        int seed_v;
        seed_v = $urandom(32'h5eed_2024);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R11", "reset out_valid", {63'd0, out_valid}, 64'd0);
        check("R11", "reset data", out_data, 64'd0);
        check("R11", "reset unpred", {63'd0, out_unpred}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11", "post-reset out_valid", {63'd0, out_valid}, 64'd0);
        check("R11", "post-reset data", out_data, 64'd0);

        // R2 nearest-away, signed and unsigned
        run(1'b1, 3'd0, 2'd2, 3'd0, 5'd1, p4(3, -3, -5, 5), 64'd0, "R2");
        run(1'b1, 3'd1, 2'd2, 3'd0, 5'd4, p4(8, 7, 24, -1), 64'd0, "R2");
        // R3 nearest-even
        run(1'b1, 3'd2, 2'd2, 3'd0, 5'd1, p4(5, 7, -5, 6), 64'd0, "R3");
        run(1'b1, 3'd3, 2'd2, 3'd0, 5'd2, p4(6, 2, 10, 14), 64'd0, "R3");
        // R4 truncation
        run(1'b1, 3'd4, 2'd2, 3'd0, 5'd1, p4(-5, 5, -4, -1), 64'd0, "R4");
        run(1'b1, 3'd5, 2'd2, 3'd0, 5'd3, p4(15, -1, 8, 7), 64'd0, "R4");
        // R5 saturation
        run(1'b1, 3'd0, 2'd2, 3'd0, 5'd0, p4(64'h7F_FFFF, -65536, 32767, -32768), 64'd0, "R5");
        run(1'b1, 3'd1, 2'd1, 3'd0, 5'd0, p4(-1, 64'h12_3456, -1, 0), o4(16'd40, 16'd0, 16'd47, 16'd3), "R5");
        // R7 wide shifts via per-lane select
        run(1'b1, 3'd5, 2'd1, 3'd0, 5'd0, p4(64'h8000_0000_0001, 64'h8000_0000_0000, 64'h7FFF_FFFF_FFFF, -1),
            o4(16'd48, 16'd60, 16'd50, 16'h7FFF), "R7");
        run(1'b1, 3'd3, 2'd1, 3'd0, 5'd0, p4(64'h8000_0000_0001, 64'h8000_0000_0000, 64'h7FFF_FFFF_FFFF, -1),
            o4(16'd48, 16'd60, 16'd50, 16'h7FFF), "R7");
        run(1'b1, 3'd0, 2'd1, 3'd0, 5'd0, p4(-64'sh8000_0000_0000, -7, 64'h7FFF_FFFF_FFFF, 5),
            o4(16'd48, 16'd100, 16'd49, 16'd48), "R7");
        run(1'b0, 3'd5, 2'd1, 3'd0, 5'd0, {8{24'h80_0001}}, {8'd24, 8'd30, 8'd200, 8'd23, 8'd24, 8'd25, 8'd0, 8'd255}, "R7");
        // R6 byte layout
        run(1'b0, 3'd0, 2'd2, 3'd0, 5'd0, {8{24'h00_0012}}, 64'd0, "R6");
        run(1'b0, 3'd5, 2'd2, 3'd0, 5'd0, {24'h00_0123, 24'hFF_FFFF, 24'h00_00FF, 24'h00_0100,
            24'h00_0001, 24'h80_0000, 24'h00_007F, 24'h00_0000}, 64'd0, "R6");
        // R9 negative halfword shift on lane 1 only
        run(1'b1, 3'd0, 2'd1, 3'd0, 5'd0, p4(100, 100, 100, 100), o4(16'd2, 16'hFFFF, 16'd3, 16'd0), "R9");
        // R10 reserved modes
        run(1'b1, 3'd7, 2'd2, 3'd0, 5'd1, p4(5, 6, 7, 8), 64'd0, "R10");
        run(1'b0, 3'd6, 2'd2, 3'd0, 5'd1, {8{24'h00_0020}}, 64'd0, "R10");
        // R8 element select in both layouts
        run(1'b1, 3'd4, 2'd0, 3'd2, 5'd0, p4(64, -64, 1000, 7), o4(16'd40, 16'd40, 16'd3, 16'd40), "R8");
        run(1'b0, 3'd3, 2'd0, 3'd5, 5'd0, {24'd10, 24'd11, 24'd12, 24'd13, 24'd14, 24'd15, 24'd16, 24'd17},
            64'h0001_0200_0000_0000, "R8");
        run(1'b0, 3'd1, 2'd3, 3'd0, 5'd2, {24'd10, 24'd11, 24'd12, 24'd13, 24'd14, 24'd1022, 24'd6, 24'd5},
            64'hFFFF_FFFF_FFFF_FFFF, "R8");
        idle_check();

        // Constrained random traffic
        for (int n = 0; n < 3000; n++) begin
            logic f;
            logic [2:0] m;
            logic [191:0] acc;
            logic [63:0] op;
            f = 1'($urandom_range(0, 1));
            m = 3'($urandom_range(0, 7));
            acc = {$urandom(), $urandom(), $urandom(), $urandom(), $urandom(), $urandom()};
            if ($urandom_range(0, 1) == 1) begin
                for (int i = 0; i < 8; i++) begin
                    logic [11:0] sm;
                    sm = 12'($urandom());
                    if (f) acc[i*24 +: 24] = {{12{sm[11]}}, sm};
                    else   acc[i*24 +: 24] = {12'd0, sm};
                end
            end
            op = '0;
            if (f) begin
                for (int i = 0; i < 4; i++) begin
                    int r;
                    r = $urandom_range(0, 15);
                    if (r < 12)      op[i*16 +: 16] = 16'($urandom_range(0, 20));
                    else if (r < 14) op[i*16 +: 16] = 16'($urandom_range(40, 60));
                    else if (r < 15) op[i*16 +: 16] = 16'($urandom());
                    else             op[i*16 +: 16] = 16'hFFF0;
                end
            end else begin
                for (int i = 0; i < 8; i++) begin
                    int r;
                    r = $urandom_range(0, 15);
                    if (r < 12)      op[i*8 +: 8] = 8'($urandom_range(0, 12));
                    else if (r < 14) op[i*8 +: 8] = 8'($urandom_range(20, 40));
                    else             op[i*8 +: 8] = 8'($urandom());
                end
            end
            run(f, m, 2'($urandom_range(0, 3)), 3'($urandom_range(0, 7)), 5'($urandom_range(0, 31)),
                acc, op, tag_for(f, m));
            if (n % 50 == 49) idle_check();
        end

        in_valid = 1'b0;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule